// File: doc/BRIEF.md
# Per-Core Interrupt Countdown Timer

This block is a countdown timer that sits beside each processor core. Software loads a starting value into the initial-count register. The block then decrements a current-count register once per divided bus tick. When the count reaches zero it sends a one-cycle interrupt request, tagged with a programmed vector, to the core's interrupt tracker. A timer-entry register holds the vector, a mask bit and a one-shot/periodic mode bit. A divide register picks the prescale ratio, from 1 to 128 bus ticks per decrement.

The register port writes in one cycle and reads combinationally. Addresses are 0 for the timer entry, 1 for the initial count, 2 for the current count and 3 for the divide setting. A zero initial count leaves the timer idle. In periodic mode the counter reloads in the same tick that reaches zero, so no tick is lost and every period is exactly the initial count. The request goes to `irq_valid`/`irq_vector`. Decoding of the wider bus and reporting of delivery state are done elsewhere.

Top module: `core_irq_timer`

## Requirements
- R1: A write to the initial count (address 1) loads the current count with the written value on that clock edge and restarts the prescaler phase. The first decrement comes a full divide period later, even while a countdown is already in progress.
- R2: While the initial count is zero, the current count stays at zero and no request is raised.
- R3: The current count decreases by exactly one per divided tick. A divided tick is counted only in cycles where `bus_tick` is high. Cycles with `bus_tick` low leave the count unchanged.
- R4: In one-shot mode (timer entry bit 17 = 0), the tick that takes the count from 1 to 0 raises one request. The count then stays at zero with no further requests.
- R5: In periodic mode (bit 17 = 1), the tick that would reach zero reloads the initial count instead, with no leftover. Requests therefore repeat exactly every initial-count divided ticks.
- R6: On expiry, `irq_valid` is high for exactly one cycle, starting after the expiring edge, and `irq_vector` carries timer entry bits 7:0. When mask bit 16 is set, no request is raised, but counting and reloading go on as normal.
- R7: The divide setting uses write-data bits 3, 1 and 0 as a 3-bit code {b3,b1,b0}: 000=/2, 001=/4, 010=/8, 011=/16, 100=/32, 101=/64, 110=/128, 111=/1. Reading address 3 returns those bits in the same positions.
- R8: A divide write takes effect from the next edge and restarts the prescaler phase. The current count is left unchanged.
- R9: The current count (address 2) is read-only. Writes to it have no effect.
- R10: After reset, the timer entry reads 0x0001_0000 (mask set, vector 0, one-shot). The initial count, the current count and the divide code read zero, and `irq_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_tick | input | 1 | One pulse per bus clock period; feeds the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 entry, 1 initial, 2 current, 3 divide |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | CNT_W | Combinational read data |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector for the request |

## Verification
Assertions check, on every cycle, how the count moves under a tick: it goes down by one, holds without a tick, reloads in periodic mode, and sticks at zero in one-shot mode. They also check that `bus_tick` low blocks the prescaler and that a masked expiry gives no request. The bench scenarios are the only place that shows the absolute timing: the request landing at exactly initial count times divisor cycles after the load, each divide code mapping to its ratio, a restart mid-count, a divide change mid-count, and writes to the read-only count having no effect.

// File: rtl/cit_pkg.sv
package cit_pkg;
    localparam int VEC_W  = 8;
    localparam int PRE_W  = 7;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_ENTRY = 2'd0;
    localparam logic [ADDR_W-1:0] A_INIT  = 2'd1;
    localparam logic [ADDR_W-1:0] A_CUR   = 2'd2;
    localparam logic [ADDR_W-1:0] A_DIV   = 2'd3;

    localparam int BIT_MASK     = 16;
    localparam int BIT_PERIODIC = 17;

    typedef struct packed {
        logic             periodic;
        logic             masked;
        logic [VEC_W-1:0] vector;
    } entry_t;

    // code {b3,b1,b0}: 111 -> divide by 1, otherwise divide by 2^(code+1)
    function automatic logic [PRE_W-1:0] div_mask(input logic [2:0] code);
        logic [PRE_W-1:0] m;
        if (code == 3'b111) m = '0;
        else                m = PRE_W'((2 << code) - 1);
        return m;
    endfunction
endpackage

// File: rtl/cit_prescaler.sv
module cit_prescaler
    import cit_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       bus_tick,
    input  logic [2:0] div_code,
    output logic       tick
);
    logic [PRE_W-1:0] phase_q;
    logic [PRE_W-1:0] msk;

    assign msk  = div_mask(div_code);
    assign tick = bus_tick && !clr && ((phase_q & msk) == msk);

    always_ff @(posedge clk) begin
        if (rst || clr)    phase_q <= '0;
        else if (bus_tick) phase_q <= phase_q + 1'b1;
    end

    // R3: without a bus tick the prescaler never emits
    a_r3_no_bus_no_tick: assert property (@(posedge clk) disable iff (rst)
        !bus_tick |-> !tick);
    // R7: divide by one passes every bus tick
    a_r7_div1_passes: assert property (@(posedge clk) disable iff (rst)
        (div_code == 3'b111 && bus_tick && !clr) |-> tick);
endmodule

// File: rtl/cit_counter.sv
module cit_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             periodic,
    input  logic [CNT_W-1:0] init_cnt,
    output logic [CNT_W-1:0] cur_cnt,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assign expire = tick && !load && (cur_cnt == ONE);

    always_ff @(posedge clk) begin
        if (rst)
            cur_cnt <= '0;
        else if (load)
            cur_cnt <= load_val;
        else if (tick && cur_cnt != '0) begin
            if (cur_cnt == ONE) cur_cnt <= periodic ? init_cnt : '0;
            else                cur_cnt <= cur_cnt - ONE;
        end
    end

    a_r3_step_one: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && cur_cnt > ONE) |=> cur_cnt == $past(cur_cnt) - ONE);
    a_r3_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(cur_cnt));
    a_r4_oneshot_rest: assert property (@(posedge clk) disable iff (rst)
        (!periodic && !load && cur_cnt == '0) |=> cur_cnt == '0);
    a_r5_reload: assert property (@(posedge clk) disable iff (rst)
        (expire && periodic) |=> cur_cnt == $past(init_cnt));
    a_r2_zero_idle: assert property (@(posedge clk) disable iff (rst)
        (init_cnt == '0 && !load) |=> $stable(cur_cnt));
endmodule

// File: rtl/cit_regfile.sv
module cit_regfile
    import cit_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [CNT_W-1:0]  cur_cnt,
    output logic [CNT_W-1:0]  rd_data,
    output entry_t            entry,
    output logic [CNT_W-1:0]  init_cnt,
    output logic [2:0]        div_code,
    output logic              load,
    output logic              div_wr
);
    assign load   = wr_en && wr_addr == A_INIT;
    assign div_wr = wr_en && wr_addr == A_DIV;

    always_ff @(posedge clk) begin
        if (rst) begin
            entry    <= '{periodic: 1'b0, masked: 1'b1, vector: '0};
            init_cnt <= '0;
            div_code <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_ENTRY: begin
                    entry.vector   <= wr_data[VEC_W-1:0];
                    entry.masked   <= wr_data[BIT_MASK];
                    entry.periodic <= wr_data[BIT_PERIODIC];
                end
                A_INIT:  init_cnt <= wr_data;
                A_DIV:   div_code <= {wr_data[3], wr_data[1:0]};
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_ENTRY: begin
                rd_data[VEC_W-1:0]   = entry.vector;
                rd_data[BIT_MASK]     = entry.masked;
                rd_data[BIT_PERIODIC] = entry.periodic;
            end
            A_INIT:  rd_data = init_cnt;
            A_CUR:   rd_data = cur_cnt;
            default: begin
                rd_data[3]   = div_code[2];
                rd_data[1:0] = div_code[1:0];
            end
        endcase
    end
endmodule

// File: rtl/core_irq_timer.sv
module core_irq_timer
    import cit_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic              irq_valid,
    output logic [VEC_W-1:0]  irq_vector
);
    entry_t           entry;
    logic [CNT_W-1:0] init_cnt;
    logic [CNT_W-1:0] cur_cnt;
    logic [2:0]       div_code;
    logic             load;
    logic             div_wr;
    logic             tick;
    logic             expire;

    cit_regfile #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .cur_cnt(cur_cnt),
        .rd_data(rd_data), .entry(entry), .init_cnt(init_cnt),
        .div_code(div_code), .load(load), .div_wr(div_wr)
    );

    cit_prescaler u_pre (
        .clk(clk), .rst(rst), .clr(load || div_wr), .bus_tick(bus_tick),
        .div_code(div_code), .tick(tick)
    );

    cit_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .load(load), .load_val(wr_data),
        .tick(tick), .periodic(entry.periodic), .init_cnt(init_cnt),
        .cur_cnt(cur_cnt), .expire(expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_valid  <= 1'b0;
            irq_vector <= '0;
        end else begin
            irq_valid  <= expire && !entry.masked;
            irq_vector <= entry.vector;
        end
    end

    a_r6_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (expire && entry.masked) |=> !irq_valid);
    a_r6_fire_vector: assert property (@(posedge clk) disable iff (rst)
        (expire && !entry.masked) |=> (irq_valid && irq_vector == $past(entry.vector)));
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        irq_valid |=> !irq_valid);
endmodule

// File: tb/core_irq_timer_bench.sv
module core_irq_timer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_tick = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = 2'd2;
    logic [31:0] rd_data;
    logic        irq_valid;
    logic [7:0]  irq_vector;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    core_irq_timer u_core_irq_timer (
        .clk(clk), .rst(rst), .bus_tick(bus_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq_valid(irq_valid), .irq_vector(irq_vector)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
        rd_addr = 2'd2;
    endtask

    // steps n cycles, expecting a request at step first (0 = none), repeating every per (0 = once)
    task automatic watch(input string req, input int n, input int first, input int per, input logic [7:0] vec);
        for (int k = 1; k <= n; k++) begin
            logic exp_irq;
            step();
            exp_irq = (first != 0) && (k == first ||
                      (per != 0 && k > first && (k - first) % per == 0));
            check(req, {31'b0, irq_valid}, {31'b0, exp_irq});
            if (exp_irq) check(req, {24'b0, irq_vector}, {24'b0, vec});
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(2'd0, d); check("R10 entry", d, 32'h0001_0000);
        rd(2'd1, d); check("R10 init", d, 0);
        rd(2'd2, d); check("R10 cur", d, 0);
        rd(2'd3, d); check("R10 div", d, 0);
        check("R10 irq", {31'b0, irq_valid}, 0);
    endtask

    task automatic t_zero_init();
        wr(2'd0, 32'h0000_0033);
        wr(2'd3, 32'hB);
        wr(2'd1, 0);
        watch("R2 idle", 20, 0, 0, 8'h0);
        check("R2 cur", rd_data, 0);
    endtask

    task automatic t_oneshot();
        wr(2'd0, 32'h0000_0045);
        wr(2'd3, 32'hB);
        wr(2'd1, 5);
        check("R1 load", rd_data, 5);
        step(); step();
        check("R3 dec", rd_data, 3);
        watch("R4 oneshot", 3, 3, 0, 8'h45);
        check("R4 zero", rd_data, 0);
        watch("R4 stays", 10, 0, 0, 8'h0);
        check("R4 zero hold", rd_data, 0);
    endtask

    task automatic t_periodic();
        wr(2'd0, 32'h0002_0077);
        wr(2'd3, 32'hB);
        wr(2'd1, 3);
        watch("R5 periodic", 3, 3, 0, 8'h77);
        check("R5 reload", rd_data, 3);
        watch("R5 periodic", 6, 3, 3, 8'h77);
    endtask

    task automatic t_divide();
        wr(2'd0, 32'h0000_0012);
        wr(2'd3, 32'h1);
        wr(2'd1, 2);
        watch("R7 div4", 10, 8, 0, 8'h12);
        wr(2'd3, 32'h0);
        wr(2'd1, 3);
        watch("R7 div2", 8, 6, 0, 8'h12);
        wr(2'd3, 32'hA);
        wr(2'd1, 1);
        watch("R7 div128", 130, 128, 0, 8'h12);
    endtask

    task automatic t_masked();
        wr(2'd0, 32'h0003_0021);
        wr(2'd3, 32'hB);
        wr(2'd1, 4);
        step(); step();
        check("R6 masked counts", rd_data, 2);
        watch("R6 masked silent", 2, 0, 0, 8'h0);
        check("R6 masked reload", rd_data, 4);
        watch("R6 masked silent", 10, 0, 0, 8'h0);
    endtask

    task automatic t_restart();
        wr(2'd0, 32'h0000_0056);
        wr(2'd3, 32'h1);
        wr(2'd1, 10);
        for (int k = 0; k < 6; k++) step();
        check("R1 before restart", rd_data, 9);
        wr(2'd1, 2);
        check("R1 reload", rd_data, 2);
        watch("R1 restart", 10, 8, 0, 8'h56);
    endtask

    task automatic t_bus_gate();
        wr(2'd3, 32'hB);
        wr(2'd1, 10);
        bus_tick = 1'b0;
        for (int k = 0; k < 5; k++) step();
        check("R3 gated", rd_data, 10);
        bus_tick = 1'b1;
        step(); step();
        check("R3 ungated", rd_data, 8);
        wr(2'd1, 0);
    endtask

    task automatic t_div_change();
        logic [31:0] d;
        wr(2'd0, 32'h0001_0000);
        wr(2'd3, 32'hA);
        wr(2'd1, 100);
        for (int k = 0; k < 5; k++) step();
        check("R8 slow", rd_data, 100);
        wr(2'd3, 32'hB);
        check("R8 count kept", rd_data, 100);
        rd(2'd3, d); check("R7 readback", d, 32'hB);
        step(); step(); step();
        check("R8 fast", rd_data, 97);
    endtask

    task automatic t_readonly();
        logic [31:0] d;
        wr(2'd1, 0);
        wr(2'd2, 32'h55);
        rd(2'd2, d); check("R9 idle write", d, 0);
        wr(2'd3, 32'hB);
        wr(2'd1, 20);
        step(); step();
        wr(2'd2, 32'h99);
        check("R9 busy write", rd_data, 17);
        rd(2'd1, d); check("R9 init untouched", d, 20);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_zero_init();
        t_oneshot();
        t_periodic();
        t_divide();
        t_masked();
        t_restart();
        t_bus_gate();
        t_div_change();
        t_readonly();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule